// File: doc/BRIEF.md
# Reset-Time Serial Unlock Detector

This block decides where a microcontroller begins fetching after reset. It works in two address spaces, the main flash array and a boot ROM. While the external reset pin is held low, the block watches a serial data pin and a separate shift-clock pin. On every rising edge of the shift clock it takes one data bit into a code register. Bits arrive least significant first.

When the reset pin is released, the captured code is compared with a fixed 24-bit unlock word, 0x5E38AC. A match forces the boot ROM to be selected for this reset only, whatever the stored option bit says. With no match, the stored option bit chooses the space. The stored option bit is never written, so the override lasts for one reset and no longer. The decision is latched at release and held until reset is asserted again. Both spaces are entered at the same entry offset, address 0x0000.

All pins are asynchronous to the system clock. Each pin passes through its own synchroniser before any logic uses it.

Top module: `boot_unlock_top`

## Requirements
- R1: While the reset pin is low, and until the release decision has been latched, `boot_rom_sel` is 0 and `start_addr` is 0x0000.
- R2: While in reset, each rising edge of the synchronised shift clock samples the synchronised data pin into the code register. The first bit received becomes bit 0 once 24 bits have arrived (least significant bit first).
- R3: If the captured code equals 0x5E38AC at reset release, `boot_rom_sel` becomes 1 (boot ROM) whatever the value of `opt_boot_rom`.
- R4: If the code does not match at release, `boot_rom_sel` takes the value `opt_boot_rom` had at release, where 1 selects boot ROM and 0 selects flash. The unlock word sent most significant bit first does not match. The unlock word with one bit flipped does not match.
- R5: When more than 24 bits are shifted during one reset, only the last 24 received are compared.
- R6: The code register clears when reset is first asserted. Bits from an earlier reset never count, so fewer than 24 bits gives no match.
- R7: After release, the decision stays fixed until the next reset assertion. Changes on `opt_boot_rom`, `sclk_pin` or `sdata_pin` during that time have no effect.
- R8: A forced boot ROM entry lasts one reset only. A later reset with no code shifted and `opt_boot_rom` = 0 selects flash.
- R9: Out of reset, `start_addr` equals the entry offset 0x0000 for both spaces.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| sdata_pin | input | 1 | Serial unlock data pin |
| sclk_pin | input | 1 | Serial shift-clock pin; data is taken on its rising edge |
| opt_boot_rom | input | 1 | Stored boot-space option: 1 selects boot ROM, 0 selects flash |
| boot_rom_sel | output | 1 | Selected space after reset: 1 boot ROM, 0 flash |
| start_addr | output | 16 | Entry address within the selected space |

## Verification
The bench builds the block with its default parameters: a 24-bit code, the unlock word 0x5E38AC, two synchroniser stages and a 16-bit address. At 24 bits the bench can reach the exact word, the word sent in the opposite bit order, a single flipped bit, overlong streams of 28 bits and short streams of 23 bits. With two stages, a release decision settles within a few clocks, so each reset cycle in the bench stays short.

// File: rtl/boot_unlock_pkg.sv
package boot_unlock_pkg;

  typedef enum logic {
    SPACE_FLASH = 1'b0,
    SPACE_BOOT  = 1'b1
  } boot_space_e;

  localparam int          DEF_CODE_W = 24;
  localparam logic [23:0] DEF_CODE   = 24'h5E38AC;

endpackage

// File: rtl/unlock_rst_sync.sv
module unlock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pin_n,
  output logic in_reset
);
  logic [STAGES-1:0] chain;

  // assert at once, release through STAGES flops
  always_ff @(posedge clk or negedge pin_n) begin
    if (!pin_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign in_reset = ~chain[STAGES-1];
endmodule

// File: rtl/unlock_bit_sync.sv
module unlock_bit_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    stage_q[0] <= d;
    for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/unlock_shifter.sv
module unlock_shifter #(
  parameter int CODE_W = 24
) (
  input  logic              clk,
  input  logic              in_reset,
  input  logic              enter_evt,
  input  logic              shift_evt,
  input  logic              data_bit,
  output logic [CODE_W-1:0] code_q
);
  // new bit enters at the top, so the first bit ends up at bit 0
  function automatic logic [CODE_W-1:0] push_lsb_first(
    input logic [CODE_W-1:0] cur, input logic b);
    return {b, cur[CODE_W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (enter_evt)                  code_q <= '0;
    else if (in_reset && shift_evt) code_q <= push_lsb_first(code_q, data_bit);
  end

  // R6
  clear_on_entry_chk: assert property (@(posedge clk) disable iff (!in_reset)
    enter_evt |=> (code_q == '0));

  // R7
  shift_idle_chk: assert property (@(posedge clk) disable iff (in_reset)
    !in_reset |=> $stable(code_q));
endmodule

// File: rtl/unlock_decider.sv
module unlock_decider
  import boot_unlock_pkg::*;
#(
  parameter int              CODE_W      = 24,
  parameter logic [CODE_W-1:0] UNLOCK_CODE = DEF_CODE
) (
  input  logic              clk,
  input  logic              in_reset,
  input  logic              release_evt,
  input  logic [CODE_W-1:0] code_q,
  input  logic              opt_boot_rom,
  output logic              sel_q,
  output logic              code_hit
);
  function automatic logic is_unlock(input logic [CODE_W-1:0] c);
    return c == UNLOCK_CODE;
  endfunction

  assign code_hit = is_unlock(code_q);

  always_ff @(posedge clk) begin
    if (in_reset)         sel_q <= SPACE_FLASH;
    else if (release_evt) sel_q <= code_hit ? SPACE_BOOT : boot_space_e'(opt_boot_rom);
  end

  // R1
  sel_low_in_reset_chk: assert property (@(posedge clk) disable iff (1'b0)
    in_reset |=> !sel_q);

  // R3
  forced_sel_chk: assert property (@(posedge clk) disable iff (in_reset)
    (release_evt && code_hit) |=> sel_q);

  // R4
  fallback_sel_chk: assert property (@(posedge clk) disable iff (in_reset)
    (release_evt && !code_hit) |=> (sel_q == $past(opt_boot_rom)));

  // R7
  decision_hold_chk: assert property (@(posedge clk) disable iff (in_reset)
    !release_evt |=> $stable(sel_q));
endmodule

// File: rtl/boot_unlock_top.sv
module boot_unlock_top
  import boot_unlock_pkg::*;
#(
  parameter int                CODE_W      = DEF_CODE_W,
  parameter logic [CODE_W-1:0] UNLOCK_CODE = DEF_CODE,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] ENTRY_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              sdata_pin,
  input  logic              sclk_pin,
  input  logic              opt_boot_rom,
  output logic              boot_rom_sel,
  output logic [ADDR_W-1:0] start_addr
);
  localparam int PIN_W = 2;

  logic              in_reset, in_reset_d;
  logic [PIN_W-1:0]  pins_s;
  logic              sclk_s, sdata_s, sclk_d;
  logic              enter_evt, release_evt, shift_evt;
  logic [CODE_W-1:0] code_q;
  logic              sel_q, code_hit;

  unlock_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .pin_n(rst_pin_n), .in_reset(in_reset));

  unlock_bit_sync #(.STAGES(SYNC_STAGES), .W(PIN_W)) u_pins (
    .clk(clk), .d({sclk_pin, sdata_pin}), .q(pins_s));

  assign {sclk_s, sdata_s} = pins_s;

  always_ff @(posedge clk) begin
    in_reset_d <= in_reset;
    sclk_d     <= sclk_s;
  end

  // named events for the checkers
  assign enter_evt   = in_reset & ~in_reset_d;
  assign release_evt = ~in_reset & in_reset_d;
  assign shift_evt   = sclk_s & ~sclk_d;

  unlock_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk(clk), .in_reset(in_reset), .enter_evt(enter_evt),
    .shift_evt(shift_evt), .data_bit(sdata_s), .code_q(code_q));

  unlock_decider #(.CODE_W(CODE_W), .UNLOCK_CODE(UNLOCK_CODE)) u_dec (
    .clk(clk), .in_reset(in_reset), .release_evt(release_evt),
    .code_q(code_q), .opt_boot_rom(opt_boot_rom),
    .sel_q(sel_q), .code_hit(code_hit));

  assign boot_rom_sel = sel_q & ~in_reset;
  assign start_addr   = ENTRY_ADDR;

  // R9
  addr_entry_chk: assert property (@(posedge clk) disable iff (in_reset)
    1'b1 |=> (start_addr == ENTRY_ADDR));
endmodule

// File: tb/boot_unlock_top_test.sv
module boot_unlock_top_test;
  logic        clk = 1'b0;
  logic        rst_pin_n = 1'b0;
  logic        sdata_pin = 1'b0;
  logic        sclk_pin = 1'b0;
  logic        opt_boot_rom = 1'b0;
  logic        boot_rom_sel;
  logic [15:0] start_addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  boot_unlock_top uut (
    .clk(clk), .rst_pin_n(rst_pin_n), .sdata_pin(sdata_pin),
    .sclk_pin(sclk_pin), .opt_boot_rom(opt_boot_rom),
    .boot_rom_sel(boot_rom_sel), .start_addr(start_addr));

  typedef struct packed {
    logic [31:0] val;
    logic [7:0]  nbits;
    logic        msb_first;
    logic        opt;
    logic        exp_sel;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h005E38AC, 8'd24, 1'b0, 1'b0, 1'b1},  // R3 exact word
    '{32'h00000000, 8'd0,  1'b0, 1'b0, 1'b0},  // R8 R6 next reset falls back
    '{32'h005E38AC, 8'd24, 1'b1, 1'b0, 1'b0},  // R4 msb first
    '{32'h005E38AD, 8'd24, 1'b0, 1'b0, 1'b0},  // R4 one bit flipped
    '{32'h00000000, 8'd0,  1'b0, 1'b1, 1'b1},  // R4 option boot rom
    '{32'h005E38AC, 8'd24, 1'b0, 1'b1, 1'b1},  // R3 match with option set
    '{32'h05E38ACF, 8'd28, 1'b0, 1'b0, 1'b1},  // R5 last 24 kept
    '{32'h005E38AC, 8'd23, 1'b0, 1'b0, 1'b0},  // R6 short stream
    '{32'h0BADBEEF, 8'd32, 1'b0, 1'b1, 1'b1}   // R4 garbage, option
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdata_pin = b;
    cyc(3);
    sclk_pin = 1'b1;
    cyc(4);
    sclk_pin = 1'b0;
    cyc(4);
  endtask

  task automatic run_vec(input vec_t v);
    rst_pin_n = 1'b0;
    cyc(6);
    opt_boot_rom = v.opt;
    for (int i = 0; i < int'(v.nbits); i++)
      shift_bit(v.msb_first ? v.val[int'(v.nbits) - 1 - i] : v.val[i]);
    cyc(4);
    chk("R1 sel in reset", {15'd0, boot_rom_sel}, 16'd0);
    rst_pin_n = 1'b1;
    cyc(10);
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // reset state
    cyc(4);
    chk("R1 reset sel", {15'd0, boot_rom_sel}, 16'd0);
    chk("R1 reset addr", start_addr, 16'h0000);
    rst_pin_n = 1'b1;
    cyc(10);

    for (int k = 0; k < NV; k++) begin
      run_vec(VECS[k]);
      chk($sformatf("R2 R3 R4 vec%0d sel", k), {15'd0, boot_rom_sel}, {15'd0, VECS[k].exp_sel});
      chk($sformatf("R9 vec%0d addr", k), start_addr, 16'h0000);
    end

    // R7: decision held against option and pin activity after release
    run_vec(VECS[0]);
    opt_boot_rom = 1'b0;
    for (int i = 0; i < 24; i++) shift_bit(i[0]);
    chk("R7 forced held", {15'd0, boot_rom_sel}, 16'd1);
    run_vec(VECS[1]);
    opt_boot_rom = 1'b1;
    cyc(8);
    chk("R7 flash held opt change", {15'd0, boot_rom_sel}, 16'd0);
    // shift unlock word outside reset, then reset with nothing shifted
    opt_boot_rom = 1'b0;
    for (int i = 0; i < 24; i++) shift_bit(VECS[0].val[i]);
    chk("R7 shift outside reset", {15'd0, boot_rom_sel}, 16'd0);
    run_vec(VECS[1]);
    chk("R6 R7 no stale code", {15'd0, boot_rom_sel}, 16'd0);

    // R1: asynchronous drop of output at reset assertion
    run_vec(VECS[0]);
    @(negedge clk);
    #2 rst_pin_n = 1'b0;
    #1 chk("R1 async drop", {15'd0, boot_rom_sel}, 16'd0);
    cyc(4);
    rst_pin_n = 1'b1;
    cyc(10);
    chk("R8 forced one reset only", {15'd0, boot_rom_sel}, 16'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule